// File: doc/BRIEF.md
# Indexed Palette Colour Map Port

This block holds the colour map of an 8-bit pseudocolour display. It has 256 entries for pixel colours and four more for the overlay (cursor) colours, 260 entries in total. Each entry holds an 8-bit red, an 8-bit green and an 8-bit blue component. Software reaches the map through a small 32-bit register port. It first writes an entry number to the index register. It then moves the three components one at a time through a data register. After each blue component the index steps on by itself, so a run of entries can be loaded without rewriting the index.

A second data register writes to the overlay entries. It ignores the upper bits of the index and uses only its low two bits. A separate lookup port takes an entry number and returns the 24-bit colour at once, for the display and cursor pixel path. The lookup port does not depend on the register port, except that a stored component shows on it in the cycle after the write. Writes to any other register offset are dropped.

Top module: `cmap_port`

## Requirements
- R1: At reset every component of every entry is zero, except entries 255, 256 and 258, which are full white (0xFFFFFF). At reset the index and the component phase are cleared, so the first data write after reset stores the red component of entry 0.
- R2: A write to offset 0 loads the index from `reg_wdata[31:24]` and returns the phase to red.
- R3: A write to offset 4 stores `reg_wdata[31:24]` into one component of the entry that the index selects. Successive writes store red, then green, then blue.
- R4: When the blue component is written or read, the index increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R5: A write to offset 12 stores a component of entry 256 + `index[1:0]` in the same red, green, blue order. It advances the phase, and the 8-bit index, in the same way as offset 4.
- R6: A read, at any offset, returns the component that the current phase selects for the entry at the current index. The component appears in `reg_rdata[31:24]` and bits 23:0 are zero. `reg_rdata` is valid from the clock edge that takes the read and holds until the next read.
- R7: Reads and writes share one phase counter, so a read that follows a red write returns green.
- R8: A write to any offset other than 0, 4 or 12 changes no entry, no index and no phase.
- R9: `lk_rgb` returns {red, green, blue} of entry `lk_idx`, with red in bits 23:16, combinationally. A component written at a clock edge shows on it right after that edge. For entry numbers above 259 it returns zero.
- R10: When `reg_wr` and `reg_rd` are high in the same cycle, the write is carried out and the read is dropped: the phase steps only once and `reg_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | 32-bit register write strobe |
| reg_rd | input | 1 | 32-bit register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, component in bits 31:24 |
| lk_idx | input | 9 | Lookup entry number |
| lk_rgb | output | 24 | Lookup colour {R,G,B} |

## Verification
The colour on the lookup port is combinational. A component stored at one clock edge is therefore due on `lk_rgb` before the next edge. Read data is registered, so it is due one edge after the cycle in which the read strobe is high. The bench drives strobes on the falling edge and samples every result a quarter period after the rising edge. In that cycle it compares both outputs with a behavioural model that updates on the same rising edge. Directed checks then repeat the same comparisons against hand-worked values for index wrap, overlay aliasing, mixed read and write order, ignored offsets and colliding strobes.

// File: rtl/cmap_port.sv
module cmap_port #(
  parameter int CW   = 8,
  parameter int NPIX = 256,
  parameter int NOVL = 4,
  parameter int AW   = 4,
  parameter int IW   = $clog2(NPIX + NOVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [IW-1:0]   lk_idx,
  output logic [3*CW-1:0] lk_rgb
);

  localparam int NENT = NPIX + NOVL;
  localparam int XW   = $clog2(NPIX);
  localparam int OW   = $clog2(NOVL);

  typedef enum logic [1:0] {PH_R = 2'd0, PH_G = 2'd1, PH_B = 2'd2} ph_t;

  logic [CW-1:0] red [NENT];
  logic [CW-1:0] grn [NENT];
  logic [CW-1:0] blu [NENT];
  logic [XW-1:0] idx;
  ph_t           ph;

  logic hit_idx, hit_pix, hit_ovl, comp_wr, rd_take, step;
  logic [IW-1:0] tgt;
  logic [CW-1:0] wd, rd_comp;

  assign hit_idx = reg_wr && (reg_addr == AW'(0));
  assign hit_pix = reg_wr && (reg_addr == AW'(4));
  assign hit_ovl = reg_wr && (reg_addr == AW'(12));
  assign comp_wr = hit_pix || hit_ovl;
  assign rd_take = reg_rd && !reg_wr;
  assign step    = comp_wr || rd_take;
  assign wd      = reg_wdata[31 -: CW];
  assign tgt     = hit_ovl ? IW'(NPIX) + IW'(idx[OW-1:0]) : IW'(idx);

  always_comb begin
    case (ph)
      PH_G:    rd_comp = grn[IW'(idx)];
      PH_B:    rd_comp = blu[IW'(idx)];
      default: rd_comp = red[IW'(idx)];
    endcase
  end

  assign lk_rgb = (int'(lk_idx) < NENT) ? {red[lk_idx], grn[lk_idx], blu[lk_idx]} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      ph        <= PH_R;
      reg_rdata <= '0;
      for (int i = 0; i < NENT; i++) begin
        if (i == NPIX - 1 || i == NPIX || i == NPIX + 2) begin
          red[i] <= '1; grn[i] <= '1; blu[i] <= '1;
        end else begin
          red[i] <= '0; grn[i] <= '0; blu[i] <= '0;
        end
      end
    end else begin
      if (hit_idx) begin
        idx <= reg_wdata[31 -: XW];
        ph  <= PH_R;
      end else if (step) begin
        if (ph == PH_B) begin
          ph  <= PH_R;
          idx <= idx + 1'b1;
        end else begin
          ph <= ph_t'(ph + 2'd1);
        end
      end
      if (comp_wr) begin
        case (ph)
          PH_G:    grn[tgt] <= wd;
          PH_B:    blu[tgt] <= wd;
          default: red[tgt] <= wd;
        endcase
      end
      if (rd_take)
        reg_rdata <= {rd_comp, {(32-CW){1'b0}}};
    end
  end

  assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ph != 2'd3);

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_idx |=> (idx == $past(reg_wdata[31 -: XW])) && (ph == PH_R));

  assert_index_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hit_idx && ph == PH_B) |=> (idx == $past(idx) + 1'b1) && (ph == PH_R));

  assert_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !hit_idx && !comp_wr) |=> $stable(idx) && $stable(ph));

  assert_rdata_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31-CW:0] == '0);

  assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_wr) |=> $stable(reg_rdata));

endmodule

// File: tb/sim_cmap_port.sv
`timescale 1ns/1ps
module sim_cmap_port;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [8:0] lk_idx = 0;
  logic [23:0] lk_rgb;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmap_port u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_idx(lk_idx), .lk_rgb(lk_rgb));

  int m_c [0:259][0:2];
  int m_idx, m_ph;
  logic [31:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 260; i++)
        for (int k = 0; k < 3; k++)
          m_c[i][k] <= (i == 255 || i == 256 || i == 258) ? 255 : 0;
      m_idx <= 0; m_ph <= 0; m_rd <= 0;
    end else begin
      if (reg_wr) begin
        if (reg_addr == 0) begin
          m_idx <= reg_wdata[31:24]; m_ph <= 0;
        end else if (reg_addr == 4 || reg_addr == 12) begin
          m_c[(reg_addr == 12) ? 256 + (m_idx % 4) : m_idx][m_ph] <= reg_wdata[31:24];
          if (m_ph == 2) begin m_ph <= 0; m_idx <= (m_idx + 1) % 256; end
          else m_ph <= m_ph + 1;
        end
      end else if (reg_rd) begin
        m_rd <= m_c[m_idx][m_ph] << 24;
        if (m_ph == 2) begin m_ph <= 0; m_idx <= (m_idx + 1) % 256; end
        else m_ph <= m_ph + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk("R9 lookup vs model", {8'h0, lk_rgb},
          (lk_idx < 260) ? (m_c[lk_idx][0] << 16) | (m_c[lk_idx][1] << 8) | m_c[lk_idx][2] : 32'h0);
      chk("R6 rdata vs model", reg_rdata, m_rd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = {v, 24'h5A5A5A};
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = 4'd8;
    @(negedge clk); reg_rd = 0; v = reg_rdata;
  endtask

  task automatic look(input int i, input logic [23:0] exp, input string tag);
    @(negedge clk); lk_idx = 9'(i); #1; chk(tag, {8'h0, lk_rgb}, {8'h0, exp});
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(255, 24'hFFFFFF, "R1 entry255 white");
    look(256, 24'hFFFFFF, "R1 entry256 white");
    look(257, 24'h000000, "R1 entry257 zero");
    look(258, 24'hFFFFFF, "R1 entry258 white");
    look(300, 24'h000000, "R9 out of range");
    lk_idx = 0;
    wr(4, 8'h77);
    look(0, 24'h770000, "R1 first write hits entry0 red");
    wr(0, 8'h10); wr(4, 8'h11); wr(4, 8'h22);
    lk_idx = 9'h10;
    wr(4, 8'h33);
    chk("R3 entry 0x10 colour", {8'h0, lk_rgb}, 32'h00112233);
    wr(4, 8'hA1);
    look(17, 24'hA10000, "R4 index advanced after blue");
    wr(0, 8'hFF); wr(4, 8'h01); wr(4, 8'h02); wr(4, 8'h03); wr(4, 8'h44);
    look(255, 24'h010203, "R3 entry255 rewritten");
    look(0, 24'h440000, "R4 index wraps to 0");
    wr(0, 8'h07); wr(12, 8'hC1); wr(12, 8'hC2); wr(12, 8'hC3);
    look(259, 24'hC1C2C3, "R5 overlay alias entry259");
    look(7, 24'h000000, "R5 pixel entry7 untouched");
    wr(4, 8'h88);
    look(8, 24'h880000, "R5 index stepped past overlay write");
    wr(0, 8'h10);
    rd(v); chk("R6 read red", v, 32'h11000000);
    rd(v); chk("R6 read green", v, 32'h22000000);
    rd(v); chk("R6 read blue", v, 32'h33000000);
    rd(v); chk("R4 read advanced index", v, 32'hA1000000);
    wr(0, 8'h10); wr(4, 8'h99);
    rd(v); chk("R7 read after red write is green", v, 32'h22000000);
    wr(4, 8'h66);
    look(16, 24'h992266, "R7 write after read is blue");
    wr(0, 8'h20);
    wr(8, 8'hEE); wr(14, 8'hEE); wr(2, 8'hEE);
    wr(4, 8'h5C);
    look(32, 24'h5C0000, "R8 ignored offsets kept phase and index");
    look(33, 24'h000000, "R8 no entry written");
    @(negedge clk); reg_wr = 1; reg_rd = 1; reg_addr = 4; reg_wdata = 32'h6D000000;
    @(negedge clk); reg_wr = 0; reg_rd = 0;
    chk("R10 rdata held on collision", reg_rdata, 32'h22000000);
    look(32, 24'h5C6D00, "R10 write taken once");
    wr(4, 8'h4E);
    look(32, 24'h5C6D4E, "R10 phase stepped once");
    for (int i = 0; i < 264; i++) begin
      @(negedge clk); lk_idx = 9'(i);
    end
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule